// File: doc/BRIEF.md
# Debug-Mode Entry Controller

This block is the debug-entry slice of a small hart. It watches the trap events the core reports. When a breakpoint trap arrives while an external debugger is attached, the hart is steered into debug mode. The controller saves the interrupted program counter and privilege level, records why the hart stopped, forces machine privilege, and redirects fetch to a fixed debug-ROM entry address. Every other trap is passed on as an ordinary machine trap. If a debug cause is already recorded, such a trap is sent to a separate debug-ROM exception address instead of the normal trap vector.

Three debug registers sit behind a simple CSR port: a control/status word, the saved PC and a scratch word. Reads are combinational. Writes take effect at the clock edge. An access to any other address raises an illegal-access flag. Leaving debug mode is handled outside this block.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset the control word reads 32'h4000_0000 (with the debug-interrupt input low), the saved PC and scratch read 0, `dbg_active` is low, and no redirect, privilege force or machine-trap report is driven.
- R2: A trap whose cause equals `BKPT_CODE` (default 3) while `dbg_attached` is high makes the next cycle drive `npc_valid` with `npc` = `ROM_START`, pulse `prv_force_valid` with `prv_force` = 2'b11, and raise `dbg_active`. It does not report a machine trap.
- R3: On debug entry the control word's cause field (bits 8:6) becomes 1, its saved-privilege field (bits 1:0) takes `cur_prv`, and the saved PC register takes `cur_pc`.
- R4: A breakpoint trap with `dbg_attached` low, or any other trap while the cause field is 0, is an ordinary trap. The next cycle gives `npc` = `trap_vec`, and `mtrap_valid` pulses with `mtrap_cause` = the trap cause and `mtrap_epc` = `cur_pc`. Debug state is unchanged.
- R5: A non-entering trap taken while the cause field is nonzero redirects to `ROM_EXC`, and the machine-trap report is still produced.
- R6: A control-word write changes only ebreak M/H/S/U (bits 15:12), halt (bit 3), step (bit 2) and saved privilege (bits 1:0). All other written bits, including the reset request bits 22 and 21 and the cause field, have no effect.
- R7: A control-word read returns version 1 in bits 31:30 and zeros in bits 29:21, 11:9, 4 and 20:16. Bit 5 follows the live `dbg_int` input.
- R8: The saved PC (`DPC_ADDR`) and scratch (`DSCR_ADDR`) registers read back exactly what was last written.
- R9: `csr_illegal` is high exactly when `csr_en` is high and `csr_addr` is none of the three debug addresses. Such an access changes no state.
- R10: `npc_valid` is high for exactly one cycle, the cycle after a `trap_valid` pulse, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_prv | input | 2 | Current privilege level |
| trap_valid | input | 1 | One-cycle trap event |
| trap_cause | input | CAUSE_W | Trap cause code |
| trap_vec | input | XLEN | Normal machine trap vector |
| dbg_attached | input | 1 | External debugger present |
| dbg_int | input | 1 | Live debug-interrupt request |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR write (with csr_en) |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_illegal | output | 1 | Access to an unimplemented address |
| npc_valid | output | 1 | PC override valid |
| npc | output | XLEN | PC override value |
| prv_force_valid | output | 1 | Force privilege this cycle |
| prv_force | output | 2 | Forced privilege (machine) |
| dbg_active | output | 1 | Hart is in debug mode |
| mtrap_valid | output | 1 | Ordinary machine trap taken |
| mtrap_cause | output | CAUSE_W | Cause for the machine cause register |
| mtrap_epc | output | XLEN | PC for the machine exception-PC register |

## Verification
Some properties are checked on every cycle. The redirect lasts exactly one cycle and follows each trap pulse. Privilege forcing and debug entry occur only for a breakpoint with a debugger attached, and `dbg_active` stays set once raised. The control word's fixed fields and its live interrupt bit read correctly on every access, and the illegal flag matches the address decode. Other behaviours can only be shown by the bench's scenarios. These are the saved PC, privilege and cause captured at entry, the choice between the trap vector and the debug exception vector, which written bits survive a control-word write, and the fact that accesses to unknown addresses leave every register untouched.

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 4,
  parameter int BKPT_CODE = 3,
  parameter logic [XLEN-1:0] ROM_START = 32'h0000_0800,
  parameter logic [XLEN-1:0] ROM_EXC = 32'h0000_0808,
  parameter logic [11:0] DCSR_ADDR = 12'h7B0,
  parameter logic [11:0] DPC_ADDR = 12'h7B1,
  parameter logic [11:0] DSCR_ADDR = 12'h7B2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [1:0]         cur_prv,
  input  logic               trap_valid,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_vec,
  input  logic               dbg_attached,
  input  logic               dbg_int,
  input  logic               csr_en,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               csr_illegal,
  output logic               npc_valid,
  output logic [XLEN-1:0]    npc,
  output logic               prv_force_valid,
  output logic [1:0]         prv_force,
  output logic               dbg_active,
  output logic               mtrap_valid,
  output logic [CAUSE_W-1:0] mtrap_cause,
  output logic [XLEN-1:0]    mtrap_epc
);
  localparam logic [2:0] CAUSE_SWBP = 3'd1;
  localparam logic [1:0] PRV_MACH = 2'b11;
  localparam int PAD = XLEN - 32;

  logic [1:0]      sv_prv;
  logic            step_q, halt_q;
  logic [3:0]      ebrk_q;
  logic [2:0]      cause_q;
  logic [XLEN-1:0] dpc_q, scr_q;
  logic [31:0]     ctl_word;

  wire hit_dcsr = csr_addr == DCSR_ADDR;
  wire hit_dpc  = csr_addr == DPC_ADDR;
  wire hit_scr  = csr_addr == DSCR_ADDR;
  wire wr_en    = csr_en && csr_we;
  wire bkpt_hit = trap_valid && dbg_attached &&
                  (trap_cause == CAUSE_W'(BKPT_CODE));
  wire plain_trap = trap_valid && !bkpt_hit;

  assign ctl_word = {2'b01, 7'd0, 1'b0, 1'b0, 5'd0, ebrk_q, 1'b0, 1'b0, 1'b0,
                     cause_q, dbg_int, 1'b0, halt_q, step_q, sv_prv};

  generate
    if (PAD > 0) begin : g_wide
      wire [XLEN-1:0] ctl_ext = {{PAD{1'b0}}, ctl_word};
      assign csr_rdata = !csr_en ? '0 : hit_dcsr ? ctl_ext :
                         hit_dpc ? dpc_q : hit_scr ? scr_q : '0;
    end else begin : g_narrow
      assign csr_rdata = !csr_en ? '0 : hit_dcsr ? ctl_word[XLEN-1:0] :
                         hit_dpc ? dpc_q : hit_scr ? scr_q : '0;
    end
  endgenerate

  assign csr_illegal = csr_en && !(hit_dcsr || hit_dpc || hit_scr);
  assign prv_force = PRV_MACH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv_prv <= '0; step_q <= 1'b0; halt_q <= 1'b0; ebrk_q <= '0;
      cause_q <= '0; dpc_q <= '0; scr_q <= '0; dbg_active <= 1'b0;
    end else begin
      if (wr_en && hit_dcsr) begin
        ebrk_q <= csr_wdata[15:12];
        halt_q <= csr_wdata[3];
        step_q <= csr_wdata[2];
        sv_prv <= csr_wdata[1:0];
      end
      if (wr_en && hit_dpc) dpc_q <= csr_wdata;
      if (wr_en && hit_scr) scr_q <= csr_wdata;
      if (bkpt_hit) begin
        cause_q <= CAUSE_SWBP;
        sv_prv <= cur_prv;
        dpc_q <= cur_pc;
        dbg_active <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_valid <= 1'b0; npc <= '0; prv_force_valid <= 1'b0;
      mtrap_valid <= 1'b0; mtrap_cause <= '0; mtrap_epc <= '0;
    end else begin
      npc_valid <= trap_valid;
      prv_force_valid <= bkpt_hit;
      mtrap_valid <= plain_trap;
      if (bkpt_hit) npc <= ROM_START;
      else if (plain_trap) npc <= (cause_q != 3'd0) ? ROM_EXC : trap_vec;
      else npc <= '0;
      if (plain_trap) begin
        mtrap_cause <= trap_cause;
        mtrap_epc <= cur_pc;
      end
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 4,
  parameter int BKPT_CODE = 3,
  parameter logic [XLEN-1:0] ROM_START = 32'h0000_0800,
  parameter logic [11:0] DCSR_ADDR = 12'h7B0,
  parameter logic [11:0] DPC_ADDR = 12'h7B1,
  parameter logic [11:0] DSCR_ADDR = 12'h7B2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trap_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               dbg_attached,
  input logic               dbg_int,
  input logic               csr_en,
  input logic [11:0]        csr_addr,
  input logic [XLEN-1:0]    csr_rdata,
  input logic               csr_illegal,
  input logic               npc_valid,
  input logic [XLEN-1:0]    npc,
  input logic               prv_force_valid,
  input logic               dbg_active,
  input logic               mtrap_valid
);
  wire entry = trap_valid && dbg_attached && (trap_cause == CAUSE_W'(BKPT_CODE));

  AST_NPC_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> npc_valid); // R10
  AST_NPC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !npc_valid); // R10
  AST_ENTRY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (prv_force_valid && dbg_active && npc == ROM_START && !mtrap_valid)); // R2
  AST_NO_ENTRY_DETACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !entry) |=> (!prv_force_valid && mtrap_valid)); // R4
  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |=> dbg_active); // R2
  AST_CTL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == DCSR_ADDR) |->
      (csr_rdata[31:30] == 2'b01 && csr_rdata[29:16] == '0 &&
       csr_rdata[11:9] == '0 && !csr_rdata[4] && csr_rdata[5] == dbg_int)); // R7
  AST_ILLEGAL_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal == (csr_en && csr_addr != DCSR_ADDR &&
                    csr_addr != DPC_ADDR && csr_addr != DSCR_ADDR)); // R9
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .BKPT_CODE(BKPT_CODE), .ROM_START(ROM_START),
  .DCSR_ADDR(DCSR_ADDR), .DPC_ADDR(DPC_ADDR), .DSCR_ADDR(DSCR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
  .dbg_attached(dbg_attached), .dbg_int(dbg_int), .csr_en(csr_en),
  .csr_addr(csr_addr), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
  .npc_valid(npc_valid), .npc(npc), .prv_force_valid(prv_force_valid),
  .dbg_active(dbg_active), .mtrap_valid(mtrap_valid)
);

// File: tb/tb_dbg_entry_ctrl.sv
module tb_dbg_entry_ctrl;
  localparam logic [31:0] RS = 32'h0000_0800;
  localparam logic [31:0] RE = 32'h0000_0808;
  localparam logic [11:0] A_CTL = 12'h7B0, A_DPC = 12'h7B1, A_SCR = 12'h7B2;

  logic clk = 0, rst_n = 0;
  logic [31:0] cur_pc = 0, trap_vec = 0, csr_wdata = 0;
  logic [1:0] cur_prv = 0;
  logic trap_valid = 0, dbg_attached = 0, dbg_int = 0, csr_en = 0, csr_we = 0;
  logic [3:0] trap_cause = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_rdata, npc, mtrap_epc;
  logic csr_illegal, npc_valid, prv_force_valid, dbg_active, mtrap_valid;
  logic [1:0] prv_force;
  logic [3:0] mtrap_cause;

  int n_run = 0, n_fail = 0;
  logic [1:0] m_prv; logic m_step, m_halt, m_act; logic [3:0] m_eb;
  logic [2:0] m_cause; logic [31:0] m_dpc, m_scr;

  dbg_entry_ctrl dut (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] exp_ctl();
    return {2'b01, 14'd0, m_eb, 3'b000, m_cause, dbg_int, 1'b0, m_halt, m_step, m_prv};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    #1;
    chk("R9 illegal on write", {31'd0, csr_illegal},
        {31'd0, a != A_CTL && a != A_DPC && a != A_SCR});
    if (a == A_CTL) begin
      m_eb = d[15:12]; m_halt = d[3]; m_step = d[2]; m_prv = d[1:0];
    end else if (a == A_DPC) m_dpc = d;
    else if (a == A_SCR) m_scr = d;
    @(negedge clk);
    csr_en = 0; csr_we = 0;
    chk("R10 no redirect without trap", {31'd0, npc_valid}, 32'd0);
  endtask

  task automatic csr_rd(logic [11:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    csr_en = 1; csr_we = 0; csr_addr = a;
    #1;
    e = (a == A_CTL) ? exp_ctl() : (a == A_DPC) ? m_dpc : (a == A_SCR) ? m_scr : 32'd0;
    chk(tag, csr_rdata, e);
    chk("R9 illegal flag", {31'd0, csr_illegal},
        {31'd0, a != A_CTL && a != A_DPC && a != A_SCR});
    csr_en = 0;
  endtask

  task automatic do_trap(logic [3:0] c, logic att, logic [31:0] pc, logic [1:0] p, logic [31:0] tv);
    logic ent;
    ent = att && c == 4'd3;
    @(negedge clk);
    trap_valid = 1; trap_cause = c; dbg_attached = att; cur_pc = pc; cur_prv = p; trap_vec = tv;
    @(negedge clk);
    trap_valid = 0;
    chk("R10 redirect valid", {31'd0, npc_valid}, 32'd1);
    if (ent) begin
      chk("R2 npc rom start", npc, RS);
      chk("R2 force prv", {29'd0, prv_force_valid, prv_force}, {29'd0, 3'b111});
      chk("R2 active", {30'd0, dbg_active, mtrap_valid}, 32'd2);
      m_cause = 3'd1; m_prv = p; m_dpc = pc; m_act = 1;
    end else begin
      chk(m_cause != 0 ? "R5 npc exc vector" : "R4 npc trap vector",
          npc, m_cause != 0 ? RE : tv);
      chk("R4 mtrap report", {27'd0, mtrap_valid, mtrap_cause}, {27'd0, 1'b1, c});
      chk("R4 mtrap epc", mtrap_epc, pc);
      chk("R4 no force", {30'd0, prv_force_valid, dbg_active}, {31'd0, m_act});
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    m_prv = 0; m_step = 0; m_halt = 0; m_act = 0; m_eb = 0; m_cause = 0; m_dpc = 0; m_scr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {28'd0, dbg_active, npc_valid, prv_force_valid, mtrap_valid}, 32'd0);
    csr_rd(A_CTL, "R1 reset ctl");
    chk("R1 ctl value", csr_rdata, 32'h4000_0000);
    csr_rd(A_DPC, "R1 reset dpc");
    csr_rd(A_SCR, "R1 reset scratch");
    csr_wr(A_CTL, 32'hFFFF_FFFF);
    csr_rd(A_CTL, "R6 write mask all ones");
    csr_wr(A_CTL, 32'h0060_01C0);
    csr_rd(A_CTL, "R6 reset bits and cause ignored");
    dbg_int = 1;
    csr_rd(A_CTL, "R7 live debug interrupt");
    dbg_int = 0;
    csr_rd(A_CTL, "R7 debug interrupt low");
    csr_wr(A_DPC, 32'hDEAD_BEEF);
    csr_wr(A_SCR, 32'h1234_5678);
    csr_wr(12'h7B3, 32'hFFFF_FFFF);
    csr_rd(A_DPC, "R8 dpc readback");
    csr_rd(A_SCR, "R9 scratch unchanged after illegal write");
    csr_rd(12'h300, "R9 illegal read");
    do_trap(4'd3, 1'b0, 32'h100, 2'd0, 32'h200);
    do_trap(4'd2, 1'b1, 32'h104, 2'd1, 32'h200);
    for (int i = 0; i < 150; i++) begin
      case ($urandom % 4)
        0: do_trap(4'($urandom % 8) == 4'd3 ? 4'd5 : 4'($urandom % 8), $urandom % 2 == 1,
                   $urandom & 32'hFFFF_FFFC, 2'($urandom), $urandom & 32'hFFFF_FFFC);
        1: csr_wr($urandom % 2 ? A_CTL : ($urandom % 2 ? A_DPC : A_SCR), $urandom);
        2: csr_rd($urandom % 2 ? A_CTL : ($urandom % 2 ? A_DPC : A_SCR), "R8 random read");
        default: begin dbg_int = 1'($urandom); csr_rd(A_CTL, "R7 random ctl read"); end
      endcase
    end
    do_trap(4'd3, 1'b1, 32'h8000_0040, 2'd2, 32'h200);
    csr_rd(A_CTL, "R3 cause and saved prv");
    chk("R3 cause field", {29'd0, csr_rdata[8:6]}, 32'd1);
    csr_rd(A_DPC, "R3 saved pc");
    @(negedge clk);
    chk("R10 single cycle", {31'd0, npc_valid}, 32'd0);
    do_trap(4'd7, 1'b1, 32'h8000_0080, 2'd3, 32'h200);
    do_trap(4'd3, 1'b0, 32'h8000_0084, 2'd3, 32'h300);
    for (int i = 0; i < 100; i++) begin
      if ($urandom % 2) do_trap(4'($urandom % 16), $urandom % 2 == 1, $urandom, 2'($urandom), $urandom);
      else csr_rd($urandom % 2 ? A_CTL : 12'($urandom), "R9 random decode");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule